// File: doc/BRIEF.md
# Power Domain Turn-On Sequencer

This block brings one switchable power island (a display or audio island, say) from fully off to usable after a single start pulse. It owns the island's 32-bit control word. First it emits a one-cycle write of a configuration-unlock word. Then it closes the main power switch and, a cycle later, the secondary switch. It waits until the island reports power on both status buses. After that it releases the clock gate, the isolation clamp and the reset, in that order and one per cycle. Last it powers up the island's SRAM banks and waits for their acknowledge lines to drop.

Parameters select which status bit belongs to the island, which SRAM acknowledge lines it owns, which power-down bits it clears, and how many cycles each wait may take. If a wait runs out, the block raises a sticky error and goes back to idle without signalling completion. The island is then left where the sequence stopped.

Top module: `pd_wakeup_seq`

## Requirements
- R1: After reset the control word reads 0x0000_0F12. That is: reset-bar (bit 0) low, isolation (bit 1) high, main switch (bit 2) and secondary switch (bit 3) low, clock-disable (bit 4) high, SRAM power-down bits 11:8 all high, and every other bit (including SRAM clock-isolation bit 5 and SRAM isolation-release bit 6) zero. Done, error and the unlock strobe are low.
- R2: An accepted start drives the unlock strobe high for exactly one cycle, the cycle right after the start. The unlock data is the key 0xB16 in bits 31:16 with bit 0 set. The strobe comes one cycle before the main switch bit rises.
- R3: The main switch bit (bit 2) is set one cycle after the strobe. The secondary switch bit (bit 3) is set in the following cycle.
- R4: The sequence leaves the power wait only when the island's status bit is set on both the primary and the secondary status input. A single input is not enough, and status bits outside the island's mask have no effect.
- R5: After power is confirmed, clock-disable clears first. Isolation clears one cycle later, and reset-bar rises one cycle after that.
- R6: One cycle after reset-bar rises, the power-down bits selected by the mask within field 11:8 clear.
- R7: Done rises only once every SRAM acknowledge line in the island's mask (acknowledge bits 15:12 of the control register, presented as a 4-bit input) reads zero. Done stays high until the next accepted start or until reset.
- R8: In any one cycle at most one control field changes (main, secondary, clock-disable, isolation, reset-bar, power-down).
- R9: If either wait is not satisfied within WAIT_LIMIT consecutive cycles, the error flag sets and the block returns to idle without asserting done. The flag stays set until reset, and a new start is accepted after it.
- R10: A start pulse that arrives while a sequence is running is ignored. It produces no strobe and does not change the timing of completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to power the island on |
| pwr_sta_i | input | STA_W | Primary power-status bus |
| pwr_sta2_i | input | STA_W | Secondary power-status bus |
| sram_ack_i | input | ACK_W | SRAM acknowledge lines (control bits 15:12) |
| ctrl_o | output | 32 | Island control word |
| cfg_we_o | output | 1 | One-cycle write strobe for the unlock word |
| cfg_wdata_o | output | 32 | Unlock word |
| done_o | output | 1 | Island is usable |
| timeout_err_o | output | 1 | Sticky wait-timeout flag |

## Verification
The bench builds the block as an audio-style island: status bit 24 is selected, all four acknowledge lines and all four power-down bits are in the mask, and WAIT_LIMIT is 8. A limit of 8 lets both timeout paths, and the last cycle at which a late status or acknowledge still counts, appear within about twenty cycles. All status bits other than bit 24 are driven high throughout, so any decode of the wrong bit shows up as an early release.

// File: rtl/pd_wakeup_pkg.sv
package pd_wakeup_pkg;

  localparam int CTRL_W     = 32;
  localparam int B_RST_B    = 0;
  localparam int B_ISO      = 1;
  localparam int B_ON       = 2;
  localparam int B_ON2      = 3;
  localparam int B_CLKDIS   = 4;
  localparam int B_CKISO    = 5;
  localparam int B_ISOINT_B = 6;
  localparam int PDN_LO     = 8;
  localparam int PDN_W      = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ON1, ST_ON2, ST_WPWR, ST_CLK, ST_ISO, ST_RST, ST_PDN, ST_WACK
  } seq_state_e;

  typedef enum logic [2:0] {
    STEP_NONE, STEP_ON1, STEP_ON2, STEP_CLK, STEP_ISO, STEP_RST, STEP_PDN
  } ctrl_step_e;

  typedef struct packed {
    logic             on;
    logic             on2;
    logic             clk_dis;
    logic             iso;
    logic             rst_b;
    logic [PDN_W-1:0] pdn;
  } ctrl_fields_t;

  localparam ctrl_fields_t HELD_OFF = '{on: 1'b0, on2: 1'b0, clk_dis: 1'b1,
                                        iso: 1'b1, rst_b: 1'b0, pdn: '1};

endpackage

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = en && (cnt == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/pd_ctrl_word.sv
module pd_ctrl_word
  import pd_wakeup_pkg::*;
#(
  parameter logic [PDN_W-1:0] PDN_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_step_e   step,
  output ctrl_fields_t fields,
  output logic [CTRL_W-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= HELD_OFF;
    end else begin
      unique case (step)
        STEP_ON1: fields.on      <= 1'b1;
        STEP_ON2: fields.on2     <= 1'b1;
        STEP_CLK: fields.clk_dis <= 1'b0;
        STEP_ISO: fields.iso     <= 1'b0;
        STEP_RST: fields.rst_b   <= 1'b1;
        STEP_PDN: fields.pdn     <= fields.pdn & ~PDN_MASK;
        default:  fields         <= fields;
      endcase
    end
  end

  always_comb begin
    word               = '0;
    word[B_RST_B]      = fields.rst_b;
    word[B_ISO]        = fields.iso;
    word[B_ON]         = fields.on;
    word[B_ON2]        = fields.on2;
    word[B_CLKDIS]     = fields.clk_dis;
    word[B_CKISO]      = 1'b0;
    word[B_ISOINT_B]   = 1'b0;
    word[PDN_LO +: PDN_W] = fields.pdn;
  end

endmodule

// File: rtl/pd_wakeup_seq.sv
module pd_wakeup_seq
  import pd_wakeup_pkg::*;
#(
  parameter int               STA_W      = 32,
  parameter logic [STA_W-1:0] STA_MASK   = 32'h0100_0000,
  parameter int               ACK_W      = 4,
  parameter logic [ACK_W-1:0] ACK_MASK   = 4'hF,
  parameter logic [PDN_W-1:0] PDN_MASK   = 4'hF,
  parameter logic [15:0]      CFG_KEY    = 16'h0B16,
  parameter int               WAIT_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [STA_W-1:0]  pwr_sta_i,
  input  logic [STA_W-1:0]  pwr_sta2_i,
  input  logic [ACK_W-1:0]  sram_ack_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              cfg_we_o,
  output logic [31:0]       cfg_wdata_o,
  output logic              done_o,
  output logic              timeout_err_o
);

  seq_state_e   state;
  ctrl_step_e   step;
  ctrl_fields_t fields;
  logic         pwr_ok, ack_clear, tmr_en, tmr_exp;

  assign pwr_ok    = |(pwr_sta_i & STA_MASK) && |(pwr_sta2_i & STA_MASK);
  assign ack_clear = (sram_ack_i & ACK_MASK) == '0;
  assign tmr_en    = (state == ST_WPWR) || (state == ST_WACK);
  assign cfg_wdata_o = {CFG_KEY, 15'd0, 1'b1};

  pd_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(!tmr_en), .en(tmr_en), .expired(tmr_exp)
  );

  pd_ctrl_word #(.PDN_MASK(PDN_MASK)) u_ctrl (
    .clk(clk), .rst(rst), .step(step), .fields(fields), .word(ctrl_o)
  );

  always_comb begin
    unique case (state)
      ST_ON1:  step = STEP_ON1;
      ST_ON2:  step = STEP_ON2;
      ST_CLK:  step = STEP_CLK;
      ST_ISO:  step = STEP_ISO;
      ST_RST:  step = STEP_RST;
      ST_PDN:  step = STEP_PDN;
      default: step = STEP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cfg_we_o      <= 1'b0;
      done_o        <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      cfg_we_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          state    <= ST_ON1;
          cfg_we_o <= 1'b1;
          done_o   <= 1'b0;
        end
        ST_ON1:  state <= ST_ON2;
        ST_ON2:  state <= ST_WPWR;
        ST_WPWR: begin
          if (pwr_ok) state <= ST_CLK;
          else if (tmr_exp) begin
            timeout_err_o <= 1'b1;
            state         <= ST_IDLE;
          end
        end
        ST_CLK:  state <= ST_ISO;
        ST_ISO:  state <= ST_RST;
        ST_RST:  state <= ST_PDN;
        ST_PDN:  state <= ST_WACK;
        ST_WACK: begin
          if (ack_clear) begin
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else if (tmr_exp) begin
            timeout_err_o <= 1'b1;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Previous control fields, kept for the one-step-per-cycle check.
  ctrl_fields_t fields_q;
  logic [5:0]   fld_chg;
  always_ff @(posedge clk) begin
    if (rst) fields_q <= HELD_OFF;
    else     fields_q <= fields;
  end
  assign fld_chg = {fields.on != fields_q.on, fields.on2 != fields_q.on2,
                    fields.clk_dis != fields_q.clk_dis, fields.iso != fields_q.iso,
                    fields.rst_b != fields_q.rst_b, fields.pdn != fields_q.pdn};

  AST_STROBE_BEFORE_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_o[B_ON]) |-> $past(cfg_we_o));                              // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfg_we_o |=> !cfg_we_o);                                               // R10
  AST_ON2_AFTER_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_o[B_ON2]) |-> $past(ctrl_o[B_ON]));                         // R3
  AST_CLK_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_o[B_CLKDIS]) |-> $past(pwr_ok, 2));                         // R4
  AST_ISO_AFTER_CLK: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_o[B_ISO]) |-> $past(!ctrl_o[B_CLKDIS]));                    // R5
  AST_RST_AFTER_ISO: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_o[B_RST_B]) |-> $past(!ctrl_o[B_ISO]));                     // R5
  AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(ack_clear) && ctrl_o[B_RST_B]);                // R7
  AST_ONE_FIELD: assert property (@(posedge clk) disable iff (rst)
    $countones(fld_chg) <= 1);                                             // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    timeout_err_o |=> timeout_err_o);                                      // R9
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err_o) |-> !done_o);                                     // R9

endmodule

// File: tb/tb_pd_wakeup_seq.sv
module tb_pd_wakeup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LIM   = 8;
  localparam int NS    = 24;
  localparam int NV    = 8;
  localparam int NEVER = 99;
  localparam int INF   = 1000;
  localparam logic [31:0] STA_BIT = 32'h0100_0000;
  // columns: primary status at, secondary status at, ack clear at, ack pattern before, extra start at
  localparam int VT [NV][5] = '{
    '{0, 0, 0, 15, NEVER},
    '{5, 2, 0, 15, 3},
    '{2, 6, 9, 15, NEVER},
    '{0, 0, 20, 15, NEVER},
    '{NEVER, 0, 0, 15, NEVER},
    '{9, 1, 0, 15, NEVER},
    '{0, 0, 14, 15, NEVER},
    '{0, 0, 11, 8, NEVER}
  };

  logic clk = 1'b0, rst, start;
  logic [31:0] sta1, sta2, ctrl, cfg_wdata;
  logic [3:0]  ack;
  logic cfg_we, done, err;
  int checks = 0, errors = 0;

  pd_wakeup_seq #(.STA_MASK(STA_BIT), .ACK_MASK(4'hF), .PDN_MASK(4'hF),
                  .WAIT_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .start_i(start), .pwr_sta_i(sta1), .pwr_sta2_i(sta2),
    .sram_ack_i(ack), .ctrl_o(ctrl), .cfg_we_o(cfg_we), .cfg_wdata_o(cfg_wdata),
    .done_o(done), .timeout_err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int n, int s1, int s2, int a, int pat);
    sta1 = ~STA_BIT | ((n >= s1) ? STA_BIT : 32'd0);   // R4: other bits held high
    sta2 = ~STA_BIT | ((n >= s2) ? STA_BIT : 32'd0);
    ack  = (n >= a) ? 4'd0 : 4'(pat);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    drive(-1, NEVER, NEVER, NEVER, 15);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 ctrl", ctrl, 32'h0000_0F12);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 strobe", {31'd0, cfg_we}, 32'd0);
    chk("R2 data", cfg_wdata, 32'h0B16_0001);
  endtask

  // Runs one start; err_pre is the error flag expected from earlier runs.
  task automatic run_seq(int s1, int s2, int a, int pat, int poke, bit err_pre, bit fresh);
    int ex, c, w, d, dn, tm;
    logic [31:0] exp;
    ex = (s1 > s2 ? s1 : s2) + 1;
    if (ex < 3) ex = 3;
    dn = INF; tm = INF; c = INF;
    if (ex > LIM + 2) tm = LIM + 2;
    else begin
      c = ex + 1; w = c + 4;
      d = (a + 1 > w) ? a + 1 : w;
      if (d > w + LIM - 1) tm = w + LIM - 1; else dn = d;
    end
    drive(-1, s1, s2, a, pat);
    start = 1'b1;
    for (int n = 0; n < NS; n++) begin
      @(negedge clk);
      start = (n == poke);
      chk("R2 R10 strobe", {31'd0, cfg_we}, {31'd0, n == 0});
      chk("R7 done", {31'd0, done}, {31'd0, n >= dn});
      chk("R9 err", {31'd0, err}, {31'd0, err_pre || n >= tm});
      if (fresh) begin
        exp = 32'd0;
        exp[2]    = n >= 1;
        exp[3]    = n >= 2;
        exp[4]    = !(n >= c);
        exp[1]    = !(n >= c + 1);
        exp[0]    = n >= c + 2;
        exp[11:8] = (n >= c + 3) ? 4'h0 : 4'hF;
        chk("R3 switches", ctrl & 32'hC, exp & 32'hC);
        chk("R4 R5 release", ctrl & 32'h13, exp & 32'h13);
        chk("R6 pdn", ctrl & 32'hF00, exp & 32'hF00);
        chk("R1 R8 spare", ctrl & 32'hFFFF_F0E0, 32'd0);
      end
      drive(n, s1, s2, a, pat);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    drive(-1, NEVER, NEVER, NEVER, 15);
    for (int v = 0; v < NV; v++) begin
      do_reset();
      run_seq(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], 1'b0, 1'b1);
    end
    // R7: done from the last run clears on a new start, then returns
    chk("R7 held", {31'd0, done}, 32'd1);
    run_seq(0, 0, 0, 15, NEVER, 1'b0, 1'b0);
    // R9: after a power timeout the flag is sticky and a new start is accepted
    do_reset();
    run_seq(NEVER, NEVER, 0, 15, NEVER, 1'b0, 1'b1);
    run_seq(0, 0, 0, 15, NEVER, 1'b1, 1'b0);
    // R1: reset in the middle of a run brings the island back to held-off
    do_reset();
    drive(-1, NEVER, NEVER, NEVER, 15);
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    do_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule